// File: doc/BRIEF.md
# Tag Word SECDED Guard with Line Recovery

This block protects the tag words of a data cache with an extended Hamming code. It sits between the cache pipeline and the tag storage. On the write side it turns a 34-bit tag word into a 41-bit codeword for storage. On the read side it accepts the stored codeword and returns the tag word in the same cycle, so a clean read costs no extra latency. It also classifies each read as clean, correctable or uncorrectable.

A correctable read starts a recovery sequence for the affected line. The sequence has three steps. First the line is evicted through a request/acknowledge handshake. Next a one-cycle write puts the corrected codeword back into the tag store. Last a refill is requested toward the core through a second handshake.

An uncorrectable read never starts recovery. Instead it produces a one-cycle error pulse on the following cycle. A configuration input chooses whether that pulse is an immediate report or a poison marker for deferred handling. A separate flag says whether dirty data in the line may have been lost.

Top module: `tagecc_top`

## Requirements
- R1: `wr_code` is combinational from `wr_data`. `wr_code[33:0]` equals the tag word, `wr_code[39:34]` hold six Hamming check bits, and `wr_code[40]` makes the count of ones over all 41 bits even.
- R2: When `rd_code` is a codeword produced per R1, `rd_data` equals `rd_code[33:0]` in the same cycle, and both `rd_ce` and `rd_ue` stay low.
- R3: When `rd_code` differs from a valid codeword in exactly one of its 41 bits, `rd_ce` is high, `rd_ue` is low and `rd_data` is the original tag word, all in the same cycle.
- R4: When the single flipped bit lies in `rd_code[40:34]` (check or parity bits), `rd_ce` is high and `rd_data` equals `rd_code[33:0]` unchanged.
- R5: When `rd_code` differs from a valid codeword in exactly two bits, `rd_ue` is high and `rd_ce` is low.
- R6: `rd_ce` and `rd_ue` are low whenever `rd_valid` is low. A corrupted word presented without `rd_valid` starts no recovery and no error pulse.
- R7: A correctable read accepted while idle raises `evict_req` and `rcv_busy` on the next cycle, with `rcv_index` equal to the read's `rd_index`. `evict_req` then holds until a cycle in which `evict_ack` is high.
- R8: The cycle after an accepted `evict_ack`, `fix_wr_en` is high for exactly one cycle. During that cycle `fix_code` is the valid codeword of the corrected tag word.
- R9: After the fix write, `refill_req` is high until `refill_ack` is seen. On the following cycle `refill_req` and `rcv_busy` are low.
- R10: A correctable read that arrives while a recovery is in progress is ignored. `rcv_index` does not change and no second sequence follows.
- R11: An uncorrectable read with `defer_mode` low gives a one-cycle `ue_report` pulse on the next cycle, with `ue_index` equal to the read's `rd_index`. `ue_poison` stays low.
- R12: An uncorrectable read with `defer_mode` high gives a one-cycle `ue_poison` pulse on the next cycle instead, with `ue_index` set the same way. `ue_report` stays low.
- R13: `ue_data_lost` pulses together with the error pulse of R11/R12 exactly when `rd_dirty` was high on the uncorrectable read.
- R14: After a synchronous active-low reset, `evict_req`, `fix_wr_en`, `refill_req`, `rcv_busy`, `ue_report`, `ue_poison` and `ue_data_lost` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data | input | 34 | Tag word to be stored |
| wr_code | output | 41 | Encoded codeword for the tag store |
| rd_valid | input | 1 | A stored codeword is presented on `rd_code` |
| rd_index | input | 8 | Line index of the read |
| rd_dirty | input | 1 | Line holds dirty data |
| rd_code | input | 41 | Codeword read from the tag store |
| rd_data | output | 34 | Corrected tag word, same cycle |
| rd_ce | output | 1 | Correctable error on this read |
| rd_ue | output | 1 | Uncorrectable error on this read |
| defer_mode | input | 1 | 1: poison on uncorrectable, 0: report |
| evict_req | output | 1 | Request eviction of line `rcv_index` |
| evict_ack | input | 1 | Eviction done |
| fix_wr_en | output | 1 | Write `fix_code` to line `rcv_index` |
| fix_code | output | 41 | Corrected codeword |
| refill_req | output | 1 | Request refill of line `rcv_index` |
| refill_ack | input | 1 | Refill done |
| rcv_index | output | 8 | Line under recovery |
| rcv_busy | output | 1 | Recovery in progress |
| ue_report | output | 1 | Immediate uncorrectable-error report pulse |
| ue_poison | output | 1 | Deferred-error poison pulse |
| ue_index | output | 8 | Line of the last uncorrectable read |
| ue_data_lost | output | 1 | Dirty data may have been lost |

## Verification
The hardest case to reach from the ports is a second correctable read that lands while a recovery is still waiting on its eviction handshake. The stimulus reaches it by keeping `evict_ack` low after the first correctable read. It then presents another corrupted word with a different index, and confirms that the captured index and the request sequence are untouched. Flips in the check and parity bits, and double flips that include the parity bit, come from a vector table. Each vector corrupts a codeword that the block itself produced, so the bench never needs its own copy of the encoder.

// File: rtl/tagecc_pkg.sv
// Shared types and constant functions for the tag SECDED guard.
// Assumes a tag word of at most 57 bits, so check bits fit in 6 or 7 bits.
package tagecc_pkg;

    typedef enum logic [1:0] {ECC_CLEAN, ECC_CE, ECC_UE} ecc_cls_e;
    typedef enum logic [1:0] {RCV_IDLE, RCV_EVICT, RCV_FIX, RCV_REFILL} rcv_state_e;

    // Number of Hamming check bits needed for dw data bits.
    function automatic int chk_bits(int dw);
        int r;
        r = 0;
        for (int k = 7; k >= 1; k--)
            if ((1 << k) >= dw + k + 1) r = k;
        return r;
    endfunction

    // Hamming position (1-based) of data bit j; powers of two are skipped.
    function automatic int data_pos(int j);
        int c;
        int r;
        c = 0;
        r = 0;
        for (int q = 3; q < 128; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (c == j && r == 0) r = q;
                c++;
            end
        end
        return r;
    endfunction

    // Mask of data bits covered by check bit i.
    function automatic logic [63:0] chk_mask(int dw, int i);
        logic [63:0] m;
        int p;
        m = '0;
        for (int j = 0; j < dw; j++) begin
            p = data_pos(j);
            m[j] = p[i];
        end
        return m;
    endfunction

endpackage

// File: rtl/tagecc_enc.sv
// Hamming check-bit generator for one tag word. Pure combinational.
// Assumes DATA_W <= 57; the overall parity bit is formed by the caller.
module tagecc_enc
    import tagecc_pkg::*;
#(
    parameter int DATA_W = 34,
    localparam int CHK_W = chk_bits(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);
    for (genvar i = 0; i < CHK_W; i++) begin : g_chk
        localparam logic [63:0] MASK = chk_mask(DATA_W, i);
        // Check bit i is the parity over its covered data bits.
        assign chk[i] = ^(data & MASK[DATA_W-1:0]);
    end
endmodule

// File: rtl/tagecc_dec.sv
// Syndrome decoder: classifies a codeword and corrects a single data-bit flip.
// Assumes chk_calc is the check-bit recompute over the received data bits.
// Codeword layout: [DATA_W-1:0] data, then CHK_W check bits, then parity.
module tagecc_dec
    import tagecc_pkg::*;
#(
    parameter int DATA_W = 34,
    localparam int CHK_W  = chk_bits(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W + 1,
    localparam int NPOS   = DATA_W + CHK_W
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CHK_W-1:0]  chk_calc,
    output logic [DATA_W-1:0] data_fix,
    output ecc_cls_e          cls
);
    localparam logic [CHK_W-1:0] LAST_POS = CHK_W'(NPOS);

    logic [CHK_W-1:0] syn;
    logic             par_bad;

    assign syn     = code[DATA_W +: CHK_W] ^ chk_calc;
    assign par_bad = ^code;

    // Classify: an odd error count with a syndrome inside the word is correctable.
    always_comb begin
        if (!par_bad)
            cls = (syn == '0) ? ECC_CLEAN : ECC_UE;
        else
            cls = (syn <= LAST_POS) ? ECC_CE : ECC_UE;
    end

    for (genvar j = 0; j < DATA_W; j++) begin : g_fix
        localparam int P = data_pos(j);
        // Flip data bit j when the syndrome points at its position.
        assign data_fix[j] = code[j] ^ ((cls == ECC_CE) && (syn == CHK_W'(P)));
    end
endmodule

// File: rtl/tagecc_seq.sv
// Recovery sequencer (evict, fix write, refill) and uncorrectable-error pulser.
// Assumes start is only meaningful together with the read it qualifies;
// starts while busy are dropped.
module tagecc_seq
    import tagecc_pkg::*;
#(
    parameter int DATA_W = 34,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_index,
    input  logic [DATA_W-1:0] start_data,
    input  logic              ue_hit,
    input  logic              ue_dirty,
    input  logic              defer_mode,
    input  logic              evict_ack,
    input  logic              refill_ack,
    output logic              evict_req,
    output logic              fix_wr_en,
    output logic              refill_req,
    output logic              busy,
    output logic [IDX_W-1:0]  rcv_index,
    output logic [DATA_W-1:0] rcv_data,
    output logic              ue_report,
    output logic              ue_poison,
    output logic [IDX_W-1:0]  ue_index,
    output logic              ue_data_lost
);
    rcv_state_e state, state_nx;

    // Next-state selection for the recovery walk.
    always_comb begin
        state_nx = state;
        case (state)
            RCV_IDLE:   if (start)      state_nx = RCV_EVICT;
            RCV_EVICT:  if (evict_ack)  state_nx = RCV_FIX;
            RCV_FIX:                    state_nx = RCV_REFILL;
            RCV_REFILL: if (refill_ack) state_nx = RCV_IDLE;
            default:                    state_nx = RCV_IDLE;
        endcase
    end

    // State register and capture of the line under recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RCV_IDLE;
            rcv_index <= '0;
            rcv_data  <= '0;
        end else begin
            state <= state_nx;
            if (state == RCV_IDLE && start) begin
                rcv_index <= start_index;
                rcv_data  <= start_data;
            end
        end
    end

    assign evict_req  = (state == RCV_EVICT);
    assign fix_wr_en  = (state == RCV_FIX);
    assign refill_req = (state == RCV_REFILL);
    assign busy       = (state != RCV_IDLE);

    // One-cycle report or poison pulse for an uncorrectable read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ue_report    <= 1'b0;
            ue_poison    <= 1'b0;
            ue_data_lost <= 1'b0;
            ue_index     <= '0;
        end else begin
            ue_report    <= ue_hit && !defer_mode;
            ue_poison    <= ue_hit && defer_mode;
            ue_data_lost <= ue_hit && ue_dirty;
            if (ue_hit) ue_index <= start_index;
        end
    end
endmodule

// File: rtl/tagecc_top.sv
// Tag SECDED guard: write encoder, zero-latency read decoder, recovery
// sequencer. Assumes the tag store returns exactly what was written, barring
// bit upsets, and that the handshake partner holds ack for one cycle.
module tagecc_top
    import tagecc_pkg::*;
#(
    parameter int DATA_W = 34,
    parameter int IDX_W  = 8,
    localparam int CHK_W  = chk_bits(DATA_W),
    localparam int CODE_W = DATA_W + CHK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CODE_W-1:0] wr_code,
    input  logic              rd_valid,
    input  logic [IDX_W-1:0]  rd_index,
    input  logic              rd_dirty,
    input  logic [CODE_W-1:0] rd_code,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ce,
    output logic              rd_ue,
    input  logic              defer_mode,
    output logic              evict_req,
    input  logic              evict_ack,
    output logic              fix_wr_en,
    output logic [CODE_W-1:0] fix_code,
    output logic              refill_req,
    input  logic              refill_ack,
    output logic [IDX_W-1:0]  rcv_index,
    output logic              rcv_busy,
    output logic              ue_report,
    output logic              ue_poison,
    output logic [IDX_W-1:0]  ue_index,
    output logic              ue_data_lost
);
    logic [CHK_W-1:0]  wr_chk, rd_chk, fix_chk;
    logic [DATA_W-1:0] rcv_data;
    ecc_cls_e          rd_cls;

    tagecc_enc #(.DATA_W(DATA_W)) u_enc_wr (.data(wr_data), .chk(wr_chk));
    tagecc_enc #(.DATA_W(DATA_W)) u_enc_rd (.data(rd_code[DATA_W-1:0]), .chk(rd_chk));
    tagecc_enc #(.DATA_W(DATA_W)) u_enc_fix (.data(rcv_data), .chk(fix_chk));

    assign wr_code  = {^{wr_data, wr_chk}, wr_chk, wr_data};
    assign fix_code = {^{rcv_data, fix_chk}, fix_chk, rcv_data};

    tagecc_dec #(.DATA_W(DATA_W)) u_dec (
        .code(rd_code), .chk_calc(rd_chk), .data_fix(rd_data), .cls(rd_cls)
    );

    assign rd_ce = rd_valid && (rd_cls == ECC_CE);
    assign rd_ue = rd_valid && (rd_cls == ECC_UE);

    tagecc_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(rd_ce), .start_index(rd_index), .start_data(rd_data),
        .ue_hit(rd_ue), .ue_dirty(rd_dirty), .defer_mode(defer_mode),
        .evict_ack(evict_ack), .refill_ack(refill_ack),
        .evict_req(evict_req), .fix_wr_en(fix_wr_en), .refill_req(refill_req),
        .busy(rcv_busy), .rcv_index(rcv_index), .rcv_data(rcv_data),
        .ue_report(ue_report), .ue_poison(ue_poison), .ue_index(ue_index),
        .ue_data_lost(ue_data_lost)
    );
endmodule

// File: rtl/tagecc_chk.sv
// Protocol checker for tagecc_top, attached by bind.
// Assumes the synchronous active-low reset of the top.
module tagecc_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_valid,
    input logic             rd_ce,
    input logic             rd_ue,
    input logic             defer_mode,
    input logic             evict_req,
    input logic             evict_ack,
    input logic             fix_wr_en,
    input logic             refill_req,
    input logic             refill_ack,
    input logic [IDX_W-1:0] rcv_index,
    input logic             ue_report,
    input logic             ue_poison
);
    assert_ce_ue_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_ce && rd_ue));

    assert_flags_need_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (!rd_ce && !rd_ue));

    assert_evict_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_req && !evict_ack) |=> evict_req);

    assert_busy_index_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_req && !evict_ack) |=> $stable(rcv_index));

    assert_fix_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fix_wr_en |=> (!fix_wr_en && refill_req));

    assert_evict_to_fix_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_req && evict_ack) |=> fix_wr_en);

    assert_refill_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_req && refill_ack) |=> !refill_req);

    assert_one_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evict_req, fix_wr_en, refill_req}));

    assert_report_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ue && !defer_mode) |=> (ue_report && !ue_poison));

    assert_poison_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ue && defer_mode) |=> (ue_poison && !ue_report));
endmodule

bind tagecc_top tagecc_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ce(rd_ce), .rd_ue(rd_ue),
    .defer_mode(defer_mode), .evict_req(evict_req), .evict_ack(evict_ack),
    .fix_wr_en(fix_wr_en), .refill_req(refill_req), .refill_ack(refill_ack),
    .rcv_index(rcv_index), .ue_report(ue_report), .ue_poison(ue_poison)
);

// File: tb/tb_tagecc_top.sv
module tb_tagecc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [33:0] wr_data = '0;
    logic [40:0] wr_code;
    logic        rd_valid = 1'b0;
    logic [7:0]  rd_index = '0;
    logic        rd_dirty = 1'b0;
    logic [40:0] rd_code = '0;
    logic [33:0] rd_data;
    logic        rd_ce, rd_ue;
    logic        defer_mode = 1'b0;
    logic        evict_req, evict_ack = 1'b0;
    logic        fix_wr_en;
    logic [40:0] fix_code;
    logic        refill_req, refill_ack = 1'b0;
    logic [7:0]  rcv_index;
    logic        rcv_busy;
    logic        ue_report, ue_poison, ue_data_lost;
    logic [7:0]  ue_index;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    tagecc_top dut (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_code(wr_code),
        .rd_valid(rd_valid), .rd_index(rd_index), .rd_dirty(rd_dirty),
        .rd_code(rd_code), .rd_data(rd_data), .rd_ce(rd_ce), .rd_ue(rd_ue),
        .defer_mode(defer_mode), .evict_req(evict_req), .evict_ack(evict_ack),
        .fix_wr_en(fix_wr_en), .fix_code(fix_code), .refill_req(refill_req),
        .refill_ack(refill_ack), .rcv_index(rcv_index), .rcv_busy(rcv_busy),
        .ue_report(ue_report), .ue_poison(ue_poison), .ue_index(ue_index),
        .ue_data_lost(ue_data_lost)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // {tag word, flip mask, class 0=clean 1=correctable 2=uncorrectable}
    localparam logic [76:0] VEC [12] = '{
        {34'h0_0000_0000, 41'h000_0000_0000, 2'd0},
        {34'h3_FFFF_FFFF, 41'h000_0000_0000, 2'd0},
        {34'h2_5A5A_A5A5, 41'h000_0000_0001, 2'd1},
        {34'h1_2345_6789, 41'h002_0000_0000, 2'd1},
        {34'h0_DEAD_BEEF, 41'h004_0000_0000, 2'd1},
        {34'h3_0F0F_0F0F, 41'h100_0000_0000, 2'd1},
        {34'h0_0000_0001, 41'h080_0000_0000, 2'd1},
        {34'h0_5555_AAAA, 41'h000_0002_0000, 2'd1},
        {34'h2_AAAA_5555, 41'h000_0000_0003, 2'd2},
        {34'h1_FFFF_0000, 41'h0C0_0000_0000, 2'd2},
        {34'h0_1357_9BDF, 41'h100_0000_0020, 2'd2},
        {34'h3_8000_0001, 41'h004_0000_0001, 2'd2}
    };

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected <5000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    logic [40:0] good;

    initial begin
        repeat (3) @(negedge clk);
        // R14: outputs quiet in reset
        check({evict_req, fix_wr_en, refill_req, rcv_busy, ue_report, ue_poison,
               ue_data_lost} == 7'b0, "R14 reset", 64'(rcv_busy), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check({evict_req, rcv_busy, ue_report} == 3'b0, "R14 after reset",
              64'(evict_req), 64'h0);

        // Table walk: acks held so background recovery completes.
        evict_ack  = 1'b1;
        refill_ack = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            wr_data = VEC[k][76:43];
            #1;
            check(wr_code[33:0] == VEC[k][76:43], "R1 data field",
                  64'(wr_code[33:0]), 64'(VEC[k][76:43]));
            check(^wr_code == 1'b0, "R1 even parity", 64'(^wr_code), 64'h0);
            rd_code  = wr_code ^ VEC[k][42:2];
            rd_index = 8'(k);
            rd_valid = 1'b1;
            #1;
            if (VEC[k][1:0] == 2'd0) begin
                check(!rd_ce && !rd_ue, "R2 clean flags", 64'({rd_ce, rd_ue}), 64'h0);
                check(rd_data == VEC[k][76:43], "R2 clean data",
                      64'(rd_data), 64'(VEC[k][76:43]));
            end else if (VEC[k][1:0] == 2'd1) begin
                check(rd_ce && !rd_ue, "R3 single flip flags", 64'({rd_ce, rd_ue}), 64'h2);
                check(rd_data == VEC[k][76:43], "R3 R4 corrected data",
                      64'(rd_data), 64'(VEC[k][76:43]));
            end else begin
                check(!rd_ce && rd_ue, "R5 double flip flags", 64'({rd_ce, rd_ue}), 64'h1);
            end
        end
        @(negedge clk);
        rd_valid = 1'b0;
        repeat (6) @(negedge clk);
        evict_ack  = 1'b0;
        refill_ack = 1'b0;
        check(!rcv_busy, "R9 idle after table", 64'(rcv_busy), 64'h0);

        // R6: corrupted word without valid does nothing
        wr_data = 34'h2_1234_5678;
        #1;
        good = wr_code;
        rd_code = good ^ 41'h000_0000_0100;
        #1;
        check(!rd_ce && !rd_ue, "R6 no valid no flags", 64'({rd_ce, rd_ue}), 64'h0);
        @(negedge clk);
        check(!evict_req && !ue_report && !ue_poison, "R6 no action",
              64'({evict_req, ue_report, ue_poison}), 64'h0);

        // R7: correctable read starts recovery
        rd_index = 8'h3C;
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        check(evict_req && rcv_busy, "R7 evict raised", 64'({evict_req, rcv_busy}), 64'h3);
        check(rcv_index == 8'h3C, "R7 index", 64'(rcv_index), 64'h3C);
        // R10: second correctable read while busy is ignored
        rd_code  = good ^ 41'h000_0000_0004;
        rd_index = 8'h11;
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(evict_req && !fix_wr_en, "R7 evict held", 64'({evict_req, fix_wr_en}), 64'h2);
        check(rcv_index == 8'h3C, "R10 index kept", 64'(rcv_index), 64'h3C);
        evict_ack = 1'b1;
        @(negedge clk);
        evict_ack = 1'b0;
        check(fix_wr_en && !evict_req, "R8 fix write", 64'({fix_wr_en, evict_req}), 64'h2);
        check(fix_code == good, "R8 fix code", 64'(fix_code), 64'(good));
        @(negedge clk);
        check(!fix_wr_en && refill_req, "R8 single fix cycle",
              64'({fix_wr_en, refill_req}), 64'h1);
        @(negedge clk);
        check(refill_req, "R9 refill held", 64'(refill_req), 64'h1);
        refill_ack = 1'b1;
        @(negedge clk);
        refill_ack = 1'b0;
        check(!refill_req && !rcv_busy, "R9 back to idle",
              64'({refill_req, rcv_busy}), 64'h0);
        @(negedge clk);
        check(!evict_req, "R10 no second sequence", 64'(evict_req), 64'h0);

        // R11 and R13: report mode, dirty line
        defer_mode = 1'b0;
        rd_dirty   = 1'b1;
        rd_code    = good ^ 41'h000_0000_0011;
        rd_index   = 8'h55;
        rd_valid   = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        check(ue_report && !ue_poison, "R11 report pulse",
              64'({ue_report, ue_poison}), 64'h2);
        check(ue_index == 8'h55, "R11 index", 64'(ue_index), 64'h55);
        check(ue_data_lost, "R13 dirty lost", 64'(ue_data_lost), 64'h1);
        check(!evict_req, "R11 no recovery on double", 64'(evict_req), 64'h0);
        @(negedge clk);
        check(!ue_report && !ue_data_lost, "R11 single pulse",
              64'({ue_report, ue_data_lost}), 64'h0);

        // R12 and R13: defer mode, clean line
        defer_mode = 1'b1;
        rd_dirty   = 1'b0;
        rd_code    = good ^ 41'h180_0000_0000;
        rd_index   = 8'hA7;
        rd_valid   = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        check(ue_poison && !ue_report, "R12 poison pulse",
              64'({ue_report, ue_poison}), 64'h1);
        check(ue_index == 8'hA7, "R12 index", 64'(ue_index), 64'hA7);
        check(!ue_data_lost, "R13 clean not lost", 64'(ue_data_lost), 64'h0);
        @(negedge clk);
        check(!ue_poison, "R12 single pulse", 64'(ue_poison), 64'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule